// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a small synchronous static memory built for a shared data path where reads and writes follow each other on every clock with no idle cycle between them. Each accepted command is registered on a rising edge. A read returns its word on a registered output one enabled edge later. A write takes its data two enabled edges after the command, so that write data and read data use the same slot relative to their commands. The data bus is split into an input port and an output port.

A command either loads a new address or continues a four-beat burst. The burst address is generated inside the block, in linear or interleaved order, and stays within an aligned group of four words. A clock-enable input freezes the whole pipeline. A chip-select input inserts a no-operation and ends a burst. An output-enable input gates the output without stalling anything. A sleep request puts the block into a retention state after a fixed number of edges and takes it out again after a fixed number of edges. While the block is asleep, commands and array writes are blocked. When a read targets a word whose delayed write is committing on that same edge, the pending data is forwarded, so the read returns the newest value.

Top module: `zbt_sram`

## Requirements
- R1: A read command is `cke_n`=0, `sel_n`=0, `adv`=0 and `we_n`=1 at a rising edge k. The addressed word appears on `rdata` with `rvalid`=1 after enabled edge k+1.
- R2: A write command is the same as a read command but with `we_n`=0. Its data is sampled from `wdata` at the second enabled edge after the command. Reads and writes may be issued on consecutive edges in any mix, with no idle cycle.
- R3: `bw_n` is captured with the command. `bw_n[i]`=0 writes bits 8i+7..8i of the word, and `bw_n[i]`=1 leaves those bits unchanged.
- R4: Suppose a read is issued on the edge right after a write to the same address. The read returns the word as updated by that write, including its byte mask.
- R5: While `cke_n`=1, every synchronous input is ignored (`sel_n`, `adv`, `we_n`, `bw_n`, `addr`, `wdata`). All pipeline, burst and output registers hold, so `rdata` and `rvalid` do not change.
- R6: A deselect is `sel_n`=1 with `adv`=0 and `cke_n`=0. It enters a no-operation, so `rvalid`=0 one edge later, and it ends any burst. After a deselect, `adv`=1 is a no-operation until a new address is loaded.
- R7: With `adv`=1 and a burst active, the block issues the next beat with the same operation as the loading command. `sel_n` and `we_n` are ignored on such beats. With `burst_linear`=1, the low two address bits of beat n are (start + n) mod 4, and the upper bits are kept.
- R8: With `burst_linear`=0, the low two address bits of beat n are start XOR n.
- R9: After the fourth beat, a further advance returns to the start address of the burst.
- R10: `oe_n`=1 forces `rdata` to zero and `rvalid` to 0 within the same cycle. It does not alter or stall the pipeline, so the held word reappears as soon as `oe_n` returns to 0.
- R11: `asleep` rises after ENTER_CYC consecutive edges with `sleep_req`=1. It falls after WAKE_CYC consecutive edges with `sleep_req`=0. These edges are counted whatever the value of `cke_n`.
- R12: While `asleep`=1, commands are treated as no-operations, array writes are blocked, and stored contents are kept.
- R13: After reset, `rvalid`=0, `rdata`=0, `asleep`=0, and no burst is active, so `adv`=1 produces no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| sel_n | input | 1 | Active-low chip select, sampled only when `adv`=0 |
| adv | input | 1 | 1 continues the burst, 0 loads a new command |
| we_n | input | 1 | 0 for write, 1 for read on a load |
| bw_n | input | NB | Active-low byte write enables |
| addr | input | AW | Word address for a load |
| burst_linear | input | 1 | 1 linear burst order, 0 interleaved |
| oe_n | input | 1 | Active-low output enable, combinational |
| sleep_req | input | 1 | Request to enter the retention state |
| wdata | input | 8*NB | Write data, two enabled edges after the command |
| rdata | output | 8*NB | Read data, zero when idle or disabled |
| rvalid | output | 1 | `rdata` holds a read result |
| asleep | output | 1 | Block is in the retention state |

## Verification
The bench builds the block with its defaults: a 64-word array of four byte lanes, with two-edge sleep entry and wake windows. Sixty-four words allow several aligned four-word groups, so linear and interleaved bursts, wrap-around and byte masks can be checked at distinct addresses without aliasing. The two-edge sleep windows let the bench check both the edge on which `asleep` does not yet change and the edge on which it does. They also let it count the wake window through stalled cycles.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // Offset inside an aligned group of four for beat `step` of a burst.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input logic       linear);
    if (linear) return start + step;
    return start ^ step;
  endfunction

endpackage

// File: rtl/zbt_cmd_ctl.sv
module zbt_cmd_ctl
  import zbt_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          blocked,
  input  logic          sel_n,
  input  logic          adv,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  input  logic          linear,
  output op_e           a_op,
  output logic [AW-1:0] a_addr,
  output logic [NB-1:0] a_bw_n
);

  logic          bst_vld, bst_wr;
  logic [AW-1:0] bst_base;
  logic [1:0]    bst_cnt, step_nx;
  logic [AW-1:0] adv_addr;
  logic          live, ev_load, ev_adv, ev_desel;

  assign live     = en && !blocked;
  assign ev_load  = live && !adv && !sel_n;
  assign ev_desel = live && !adv && sel_n;
  assign ev_adv   = live && adv && bst_vld;

  always_comb begin
    step_nx  = bst_cnt + 2'd1;
    adv_addr = {bst_base[AW-1:2], burst_offset(bst_base[1:0], step_nx, linear)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_op     <= OP_NOP;
      a_addr   <= '0;
      a_bw_n   <= '1;
      bst_vld  <= 1'b0;
      bst_wr   <= 1'b0;
      bst_base <= '0;
      bst_cnt  <= '0;
    end else if (en) begin
      a_bw_n <= bw_n;
      if (ev_load) begin
        a_op     <= we_n ? OP_RD : OP_WR;
        a_addr   <= addr;
        bst_vld  <= 1'b1;
        bst_wr   <= !we_n;
        bst_base <= addr;
        bst_cnt  <= '0;
      end else if (ev_adv) begin
        a_op    <= bst_wr ? OP_WR : OP_RD;
        a_addr  <= adv_addr;
        bst_cnt <= step_nx;
      end else begin
        a_op <= OP_NOP;
        if (ev_desel) bst_vld <= 1'b0;
      end
    end
  end

  logic chk_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_ok <= 1'b0;
    else        chk_ok <= 1'b1;
  end

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    !en |=> $stable(a_op) && $stable(a_addr) && $stable(a_bw_n));

  a_r1_load_capture: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    ev_load |=> (a_addr == $past(addr)) && (a_op != OP_NOP));

  a_r9_burst_in_block: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    ev_adv |=> a_addr[AW-1:2] == $past(a_addr[AW-1:2]));

endmodule

// File: rtl/zbt_sleep_ctl.sv
module zbt_sleep_ctl #(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned WAKE_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep
);

  localparam int unsigned MAXC = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt, lim;
  logic          pending, ev_flip;

  assign lim     = asleep ? CW'(WAKE_CYC - 1) : CW'(ENTER_CYC - 1);
  assign pending = sleep_req != asleep;
  assign ev_flip = pending && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep <= 1'b0;
      cnt    <= '0;
    end else if (ev_flip) begin
      asleep <= !asleep;
      cnt    <= '0;
    end else if (pending) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  logic chk_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_ok <= 1'b0;
    else        chk_ok <= 1'b1;
  end

  a_r11_enter_needs_req: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    $rose(asleep) |-> $past(sleep_req));

  a_r11_exit_needs_release: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    $fell(asleep) |-> !$past(sleep_req));

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NB-1:0]   wr_bw_n,
  input  logic [8*NB-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [8*NB-1:0] rd_data,
  output logic            ev_fwd
);

  localparam int unsigned DEPTH = 1 << AW;

  assign ev_fwd = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wr_bw_n[g]) lane_mem[wr_addr] <= wr_data[g*8 +: 8];
    end

    assign rd_data[g*8 +: 8] = (ev_fwd && !wr_bw_n[g]) ? wr_data[g*8 +: 8]
                                                         : lane_mem[rd_addr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned AW        = 6,
  parameter int unsigned NB        = 4,
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned WAKE_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke_n,
  input  logic            sel_n,
  input  logic            adv,
  input  logic            we_n,
  input  logic [NB-1:0]   bw_n,
  input  logic [AW-1:0]   addr,
  input  logic            burst_linear,
  input  logic            oe_n,
  input  logic            sleep_req,
  input  logic [8*NB-1:0] wdata,
  output logic [8*NB-1:0] rdata,
  output logic            rvalid,
  output logic            asleep
);

  localparam int unsigned DW = 8 * NB;

  logic          en;
  op_e           a_op, b_op;
  logic [AW-1:0] a_addr, b_addr;
  logic [NB-1:0] a_bw_n, b_bw_n;
  logic          commit, ev_fwd;
  logic [DW-1:0] rd_word, rdata_q;
  logic          rvalid_q;

  assign en     = !cke_n;
  assign commit = en && (b_op == OP_WR) && !asleep;

  zbt_sleep_ctl #(.ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .asleep    (asleep)
  );

  zbt_cmd_ctl #(.AW(AW), .NB(NB)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .blocked (asleep),
    .sel_n   (sel_n),
    .adv     (adv),
    .we_n    (we_n),
    .bw_n    (bw_n),
    .addr    (addr),
    .linear  (burst_linear),
    .a_op    (a_op),
    .a_addr  (a_addr),
    .a_bw_n  (a_bw_n)
  );

  zbt_array #(.AW(AW), .NB(NB)) u_array (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (b_addr),
    .wr_bw_n (b_bw_n),
    .wr_data (wdata),
    .rd_addr (a_addr),
    .rd_data (rd_word),
    .ev_fwd  (ev_fwd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_op     <= OP_NOP;
      b_addr   <= '0;
      b_bw_n   <= '1;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (en) begin
      b_op     <= a_op;
      b_addr   <= a_addr;
      b_bw_n   <= a_bw_n;
      rvalid_q <= (a_op == OP_RD);
      if (a_op == OP_RD) rdata_q <= rd_word;
    end
  end

  assign rvalid = rvalid_q && !oe_n;
  assign rdata  = rvalid ? rdata_q : '0;

  logic chk_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_ok <= 1'b0;
    else        chk_ok <= 1'b1;
  end

  a_r5_output_hold: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    !en |=> $stable(rvalid_q) && $stable(rdata_q));

  a_r1_valid_from_read: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    $rose(rvalid_q) |-> $past(a_op == OP_RD));

  a_r12_asleep_nop: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    (asleep && en) |=> a_op == OP_NOP);

  a_r4_forward_full: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    (ev_fwd && en && a_op == OP_RD && b_bw_n == '0) |=> rdata_q == $past(wdata));

endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;

  logic        clk = 1'b0;
  logic        rst_n, cke_n, sel_n, adv, we_n, burst_linear, oe_n, sleep_req;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid, asleep;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  zbt_sram i_zbt_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_n(sel_n), .adv(adv),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .burst_linear(burst_linear),
    .oe_n(oe_n), .sleep_req(sleep_req), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .asleep(asleep)
  );

  localparam logic [31:0] D1 = 32'h1111_0001, D2 = 32'h2222_0002, D3 = 32'h3333_0003;
  localparam logic [31:0] E2 = 32'h2E2E_0202;
  localparam logic [31:0] V4 = 32'h4444_0004, V5 = 32'h5555_0005;
  localparam logic [31:0] V6 = 32'h6666_0006, V7 = 32'h7777_0007;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c_n, input logic s_n, input logic a, input logic w_n,
                     input logic [3:0] b, input logic [5:0] ad, input logic [31:0] wd);
    cke_n = c_n; sel_n = s_n; adv = a; we_n = w_n; bw_n = b; addr = ad; wdata = wd;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] ad, input logic [31:0] wd);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, ad, wd);
  endtask
  task automatic rd(input logic [5:0] ad, input logic [31:0] wd);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'h0, ad, wd);
  endtask
  task automatic dsl(input logic [31:0] wd);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd0, wd);
  endtask
  task automatic stl(input logic [31:0] wd);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd1, wd);
  endtask
  // advance: sel_n and we_n deliberately high to show they are ignored (R7)
  task automatic nxt(input logic [31:0] wd);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'd0, wd);
  endtask

  task automatic t_reset;
    chk("R13 rvalid after reset", {31'd0, rvalid}, 32'd0);
    chk("R13 rdata after reset", rdata, 32'd0);
    chk("R13 asleep after reset", {31'd0, asleep}, 32'd0);
    nxt(32'd0);
    nxt(32'd0);
    chk("R13 advance without burst is nop", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_alternate;
    wr(6'd1, 32'd0);
    wr(6'd2, 32'd0);
    rd(6'd1, D1);
    rd(6'd2, D2);
    chk("R1 read latency data", rdata, D1);
    chk("R1 read latency valid", {31'd0, rvalid}, 32'd1);
    wr(6'd3, 32'd0);
    chk("R2 late write data stored", rdata, D2);
    rd(6'd3, 32'd0);
    chk("R2 write slot gives no read", {31'd0, rvalid}, 32'd0);
    dsl(D3);
    chk("R4 forwarded pending write", rdata, D3);
    dsl(32'd0);
    chk("R6 deselect gives idle output", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_bytes;
    wr(6'd5, 32'd0);
    dsl(32'd0);
    dsl(32'h1122_3344);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'b1010, 6'd5, 32'd0);
    dsl(32'd0);
    dsl(32'hAABB_CCDD);
    rd(6'd5, 32'd0);
    dsl(32'd0);
    chk("R3 byte mask merge", rdata, 32'h11BB_33DD);
  endtask

  task automatic t_stall;
    rd(6'd1, 32'd0);
    stl(32'd0);
    chk("R5 stall holds idle output", {31'd0, rvalid}, 32'd0);
    dsl(32'd0);
    chk("R5 read completes after stall", rdata, D1);
    stl(32'hFFFF_FFFF);
    chk("R5 output held during stall", rdata, D1);
    chk("R5 valid held during stall", {31'd0, rvalid}, 32'd1);
    wr(6'd2, 32'd0);
    dsl(32'd0);
    stl(32'hDEAD_BEEF);
    dsl(E2);
    rd(6'd2, 32'd0);
    dsl(32'd0);
    chk("R5 write data taken on enabled edge", rdata, E2);
    rd(6'd1, 32'd0);
    dsl(32'd0);
    chk("R5 stalled write command ignored", rdata, D1);
  endtask

  task automatic t_burst;
    burst_linear = 1'b1;
    wr(6'd4, 32'd0);
    nxt(32'd0);
    nxt(V4);
    nxt(V5);
    dsl(V6);
    dsl(V7);
    rd(6'd6, 32'd0);
    nxt(32'd0);
    chk("R7 linear beat0", rdata, V6);
    nxt(32'd0);
    chk("R7 linear beat1", rdata, V7);
    nxt(32'd0);
    chk("R7 linear beat2", rdata, V4);
    nxt(32'd0);
    chk("R7 linear beat3", rdata, V5);
    dsl(32'd0);
    chk("R9 wrap to start", rdata, V6);
    burst_linear = 1'b0;
    rd(6'd5, 32'd0);
    nxt(32'd0);
    chk("R8 interleaved beat0", rdata, V5);
    nxt(32'd0);
    chk("R8 interleaved beat1", rdata, V4);
    nxt(32'd0);
    chk("R8 interleaved beat2", rdata, V7);
    dsl(32'd0);
    chk("R8 interleaved beat3", rdata, V6);
    burst_linear = 1'b1;
  endtask

  task automatic t_desel;
    rd(6'd4, 32'd0);
    dsl(32'd0);
    chk("R6 read before deselect", rdata, V4);
    nxt(32'd0);
    chk("R6 deselect slot idle", {31'd0, rvalid}, 32'd0);
    dsl(32'd0);
    chk("R6 advance after deselect is nop", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_oe;
    rd(6'd7, 32'd0);
    oe_n = 1'b1;
    dsl(32'd0);
    chk("R10 disabled output zero", rdata, 32'd0);
    chk("R10 disabled valid low", {31'd0, rvalid}, 32'd0);
    oe_n = 1'b0;
    #1;
    chk("R10 output returns at once", rdata, V7);
    dsl(32'd0);
  endtask

  task automatic t_sleep;
    sleep_req = 1'b1;
    dsl(32'd0);
    chk("R11 not asleep after one edge", {31'd0, asleep}, 32'd0);
    dsl(32'd0);
    chk("R11 asleep after two edges", {31'd0, asleep}, 32'd1);
    wr(6'd1, 32'd0);
    rd(6'd1, 32'd0);
    dsl(32'hBAD0_0001);
    chk("R12 read ignored while asleep", {31'd0, rvalid}, 32'd0);
    dsl(32'd0);
    sleep_req = 1'b0;
    stl(32'd0);
    chk("R11 still asleep after one wake edge", {31'd0, asleep}, 32'd1);
    stl(32'd0);
    chk("R11 awake after two edges under stall", {31'd0, asleep}, 32'd0);
    rd(6'd1, 32'd0);
    dsl(32'd0);
    chk("R12 contents kept and write blocked", rdata, D1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke_n = 1'b0; sel_n = 1'b1; adv = 1'b0; we_n = 1'b1;
    bw_n = 4'hF; addr = '0; burst_linear = 1'b1; oe_n = 1'b0;
    sleep_req = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alternate();
    t_bytes();
    t_stall();
    t_burst();
    t_desel();
    t_oe();
    t_sleep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule